// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges seven event sources of a serial-port emulation peripheral into one interrupt line for the host CPU. It also supplies the byte that the CPU fetches when it takes that interrupt. An event arrives as a one-cycle pulse and is held as a pending flag until software acknowledges it. An enable register has one master bit and one bit for each source. A fixed-priority encoder picks the most urgent source that is both pending and enabled.

The vector register can serve as an opcode or as the low half of a table address. In vectored mode, selected by an input pin, the register carries the 3-bit code of the winning source in bits 3..1 and always reads bit 0 as zero, so table entries are even. In opcode mode every bit reads back exactly as it was written.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and `irq_out` is low.
- R2: With `cpu_sel`=0 the CPU writes and reads the 8-bit enable register. Bit 7 is the master enable. Bit k (k=0..6) enables source k, which is `src_req[k]`.
- R3: While enable bit 7 is 0, `irq_out` stays low and the vectored-mode code reads 000, whatever the per-source bits and the pending flags hold.
- R4: A pulse on `src_req[k]` sets pending flag k at the next clock edge, and the flag holds afterwards. With the master bit and bit k set, `irq_out` is high from that edge onward.
- R5: A pulse on `src_ack[k]` clears pending flag k at the next edge. If `src_req[k]` and `src_ack[k]` are both high in the same cycle, the request wins and the flag stays set.
- R6: The code is k+1 for the highest-numbered source k that is pending and enabled: source 6 gives 111 and has the highest priority, source 0 gives 001. The code is 000 when no such source exists.
- R7: Vector register bits 7..4 (`cpu_sel`=1) read back the last value written in either mode.
- R8: With `vec_mode`=0, vector bits 3..0 read back the last value written.
- R9: With `vec_mode`=1, vector bits 3..1 read the live code of R6 and bit 0 reads 0. The stored bits are kept and reappear when the mode returns to 0.
- R10: Clearing an enable bit masks a pending flag without discarding it. Setting the bit again raises `irq_out` and restores the code with no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_sel | input | 1 | Register select: 0 enable register, 1 vector register |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register, combinational |
| vec_mode | input | 1 | 1 vectored mode, 0 opcode mode |
| src_req | input | 7 | Event pulses, bit k is source k |
| src_ack | input | 7 | Per-source pending clear |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
Every result here lands one clock edge after its stimulus. A write, a request pulse or an acknowledge changes registered state at the next rising edge, and `irq_out` and `cpu_rdata` follow from that state through combinational logic only. The bench drives inputs on falling edges and samples on the falling edge that follows the updating rising edge. Read data depends combinationally on `cpu_sel` and `vec_mode`, so the bench samples it a short delay after changing those inputs, with no clock needed.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned IRQV_NSRC = 7;
  localparam int unsigned IRQV_CW   = $clog2(IRQV_NSRC + 1);
endpackage

// File: rtl/irqv_rst_sync.sv
module irqv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // a new event outranks an acknowledge in the same cycle
    always_comb begin
      pend_d[g] = pend_q[g];
      if (clr_i[g]) pend_d[g] = 1'b0;
      if (set_i[g]) pend_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int unsigned N  = 7,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic          any_o
);
  // later iterations override, so the highest index wins
  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) code_o = CW'(i + 1);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mode_i,
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] vec_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned HI_W = DW - CW - 1;

  logic [DW-1:0] en_q, en_d;
  logic [DW-1:0] vec_q, vec_d;
  logic          en_we, vec_we;

  assign en_we  = wr_i && !sel_i;
  assign vec_we = wr_i &&  sel_i;

  always_comb begin
    en_d  = en_we  ? wdata_i : en_q;
    vec_d = vec_we ? wdata_i : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      vec_q <= '0;
    end else begin
      en_q  <= en_d;
      vec_q <= vec_d;
    end
  end

  logic [DW-1:0] vec_view;
  always_comb begin
    if (mode_i) vec_view = {vec_q[DW-1 -: HI_W], code_i, 1'b0};
    else        vec_view = vec_q;
    rdata_o = sel_i ? vec_view : en_q;
  end

  assign en_o  = en_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int unsigned NSRC = irqv_pkg::IRQV_NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [NSRC:0]     cpu_wdata,
  output logic [NSRC:0]     cpu_rdata,
  input  logic              vec_mode,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NSRC-1:0]   src_ack,
  output logic              irq_out
);
  localparam int unsigned DW = NSRC + 1;
  localparam int unsigned CW = $clog2(NSRC + 1);

  logic          rst_sync_n;
  logic [DW-1:0] en_q;
  logic [DW-1:0] vec_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] live;
  logic [CW-1:0]   code;
  logic            any;

  irqv_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  irqv_pending #(.N(NSRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (src_req),
    .clr_i (src_ack),
    .pend_o(pend_q)
  );

  assign live = pend_q & en_q[NSRC-1:0] & {NSRC{en_q[DW-1]}};

  irqv_prio_enc #(.N(NSRC), .CW(CW)) u_enc (
    .req_i (live),
    .code_o(code),
    .any_o (any)
  );

  irqv_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_i   (cpu_wr),
    .sel_i  (cpu_sel),
    .wdata_i(cpu_wdata),
    .mode_i (vec_mode),
    .code_i (code),
    .en_o   (en_q),
    .vec_o  (vec_q),
    .rdata_o(cpu_rdata)
  );

  assign irq_out = any;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int unsigned NSRC = 7,
  parameter int unsigned DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_sel,
  input logic            cpu_wr,
  input logic [DW-1:0]   cpu_wdata,
  input logic [DW-1:0]   cpu_rdata,
  input logic            vec_mode,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] src_ack,
  input logic            irq_out,
  input logic [DW-1:0]   en_q,
  input logic [DW-1:0]   vec_q,
  input logic [NSRC-1:0] pend_q
);
  localparam int unsigned CW = $clog2(NSRC + 1);

  a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[DW-1] |-> !irq_out);

  a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((pend_q & $past(src_req)) == $past(src_req)));

  a_r5_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_ack & ~src_req)) |=> ((pend_q & $past(src_ack & ~src_req)) == '0));

  a_r6_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && cpu_sel && !irq_out) |-> (cpu_rdata[CW:1] == '0));

  a_r6_code_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && cpu_sel && irq_out) |-> (cpu_rdata[CW:1] != '0));

  a_r7_vec_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel) |=> (vec_q == $past(cpu_wdata)));

  a_r9_even: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_mode && cpu_sel) |-> !cpu_rdata[0]);

  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(|src_ack) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind irq_vec_ctrl irqv_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cpu_sel  (cpu_sel),
  .cpu_wr   (cpu_wr),
  .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata),
  .vec_mode (vec_mode),
  .src_req  (src_req),
  .src_ack  (src_ack),
  .irq_out  (irq_out),
  .en_q     (en_q),
  .vec_q    (vec_q),
  .pend_q   (pend_q)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_sel = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       vec_mode = 1'b0;
  logic [6:0] src_req = 7'h00;
  logic [6:0] src_ack = 7'h00;
  logic       irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vec_mode(vec_mode),
    .src_req(src_req), .src_ack(src_ack), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(logic sel, logic mode, output logic [7:0] d);
    cpu_sel = sel; vec_mode = mode;
    #1 d = cpu_rdata;
  endtask

  task automatic pulse(logic [6:0] m);
    @(negedge clk); src_req = m;
    @(negedge clk); src_req = '0;
  endtask

  task automatic ack(logic [6:0] m);
    @(negedge clk); src_ack = m;
    @(negedge clk); src_ack = '0;
  endtask

  // code check: vectored-mode low nibble = {code, 0}
  task automatic chk_code(string req, logic [2:0] exp);
    logic [7:0] d;
    rd(1'b1, 1'b1, d);
    chk(req, {4'h0, d[3:0]}, {4'h0, exp, 1'b0});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b0, 1'b0, d); chk("R1 enable reset", d, 8'h00);
    rd(1'b1, 1'b0, d); chk("R1 vector reset", d, 8'h00);
    chk("R1 irq reset", {7'h0, irq_out}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(1'b0, 8'h5A); rd(1'b0, 1'b0, d); chk("R2 enable rw", d, 8'h5A);
    chk("R3 master off no irq", {7'h0, irq_out}, 8'h00);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h3B);
    rd(1'b1, 1'b0, d); chk("R8 opcode readback", d, 8'h3B);
    rd(1'b1, 1'b1, d); chk("R9 vectored idle", d, 8'h30);
    wr(1'b1, 8'hC7);
    rd(1'b1, 1'b1, d); chk("R7 upper vectored", d, 8'hC0);
    rd(1'b1, 1'b0, d); chk("R9 stored bits kept", d, 8'hC7);
  endtask

  task automatic t_single();
    wr(1'b0, 8'hFF);
    for (int i = 0; i < 7; i++) begin
      pulse(7'(1 << i));
      repeat (2) @(negedge clk);
      chk("R4 sticky irq", {7'h0, irq_out}, 8'h01);
      chk_code("R6 single code", 3'(i + 1));
      ack(7'(1 << i));
      chk("R5 ack clears", {7'h0, irq_out}, 8'h00);
    end
  endtask

  task automatic t_priority();
    pulse(7'b0010101);
    chk_code("R6 prio 4 over 2,0", 3'd5);
    ack(7'b0010000); chk_code("R6 prio 2 over 0", 3'd3);
    ack(7'b0000100); chk_code("R6 prio 0 alone", 3'd1);
    ack(7'b0000001); chk_code("R6 none", 3'd0);
    pulse(7'h7F); chk_code("R6 all pending", 3'd7);
    ack(7'h7F);
    chk("R5 ack all", {7'h0, irq_out}, 8'h00);
  endtask

  task automatic t_master();
    wr(1'b0, 8'h7F);
    pulse(7'b0001000);
    chk("R3 master off", {7'h0, irq_out}, 8'h00);
    chk_code("R3 code masked", 3'd0);
    wr(1'b0, 8'hFF);
    chk("R10 master on reasserts", {7'h0, irq_out}, 8'h01);
    chk_code("R10 code restored", 3'd4);
    ack(7'b0001000);
  endtask

  task automatic t_mask_keep();
    pulse(7'b0100000);
    wr(1'b0, 8'hDF);
    chk("R10 masked", {7'h0, irq_out}, 8'h00);
    wr(1'b0, 8'hFF);
    chk("R10 reenabled", {7'h0, irq_out}, 8'h01);
    chk_code("R10 code after reenable", 3'd6);
    ack(7'b0100000);
    wr(1'b0, 8'h81);
    pulse(7'b1000000);
    chk("R3 disabled source no irq", {7'h0, irq_out}, 8'h00);
    pulse(7'b0000001);
    chk_code("R6 masked high source skipped", 3'd1);
    wr(1'b0, 8'hFF);
    chk_code("R10 high source kept", 3'd7);
    ack(7'h7F);
  endtask

  task automatic t_collide();
    @(negedge clk); src_req = 7'b0000010; src_ack = 7'b0000010;
    @(negedge clk); src_req = '0; src_ack = '0;
    chk("R5 request wins", {7'h0, irq_out}, 8'h01);
    chk_code("R5 code after collide", 3'd2);
    ack(7'b0000010);
    chk("R5 cleared after", {7'h0, irq_out}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_single();
    t_priority();
    t_master();
    t_mask_keep();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule